// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select waveform for an SPI master. Every duration is programmed in core-clock cycles, stored as the count minus one. The SCK high and low times are set independently. Chip-select has its own lead-in (setup), tail (hold) and inter-frame gap (idle) phases. The clock idle level, the launch/capture phase and the active level of chip-select are all programmable.

A shift engine sits next to the block and talks to it through two valid/ready handshakes. The first one opens a frame. In the second, the timer asks for one bit at a time. It raises `bit_ready` in the last cycle of the setup phase and in the last cycle of every bit period. If `bit_valid` is high in that cycle, the bit is taken and another SCK period follows. If `bit_valid` is low, no bit is taken and the frame goes into its hold phase, so a low `bit_valid` ends the frame rather than stalling it. `start_ready` is high only while the timer is idle and outside the inter-frame gap. `bit_ready` never depends on `bit_valid`. The block emits a launch strobe (`shift_stb`) and a capture strobe (`sample_stb`). The capture strobe can be moved to the other SCK edge and then delayed by 0 to 7 core cycles.

All configuration inputs must be held stable while a frame is in progress.

Top module: `spi_sck_cs_timer`

## Requirements
- R1: During and right after reset, CS is at its inactive level, SCK is at `cfg_cpol`, `start_ready` is 1, and `bit_ready`, `shift_stb` and `sample_stb` are 0.
- R2: CS is driven to `cfg_cs_active_high` while a frame is open and to its inverse otherwise.
- R3: CS becomes active in the cycle after `start_valid && start_ready`. If `bit_valid` is high when setup ends, the first SCK leading edge comes `cfg_cs_setup`+1 cycles after CS becomes active.
- R4: Outside the first half of a bit period, SCK rests at `cfg_cpol`. The first half of each bit period is at the inverse of `cfg_cpol`.
- R5: SCK is high for `cfg_sck_high`+1 cycles and low for `cfg_sck_low`+1 cycles in every bit period.
- R6: If `cfg_sck_high`+`cfg_sck_low` is below 2 (a period under 4 cycles), both halves last 2 cycles instead.
- R7: `bit_ready` is 1 exactly in the last cycle of setup and in the last cycle of each bit period. A bit is taken when `bit_valid` is also 1. If `bit_valid` is 0 in such a cycle, the hold phase follows.
- R8: After the last bit (or after setup when no bit is taken), CS stays active for `cfg_cs_hold`+1 cycles.
- R9: After CS goes inactive, `start_ready` stays 0 for `cfg_cs_idle`+1 cycles.
- R10: With `cfg_cpha`=0, `shift_stb` pulses in the cycle a bit is taken. With `cfg_cpha`=1, it pulses in the first cycle of the bit's first SCK half (the leading edge).
- R11: The capture edge is the leading edge (first cycle of the first half) when `cfg_cpha` equals `cfg_sample_swap`, and the trailing edge (first cycle of the second half) otherwise. `sample_stb` pulses `cfg_tick_delay` cycles after that edge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sck_high | input | 16 | SCK high time minus one |
| cfg_sck_low | input | 16 | SCK low time minus one |
| cfg_cs_setup | input | 16 | CS lead-in before first edge, minus one |
| cfg_cs_hold | input | 16 | CS tail after last bit, minus one |
| cfg_cs_idle | input | 8 | Inactive gap between frames, minus one |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: launch on leading edge |
| cfg_cs_active_high | input | 1 | Active level of CS |
| cfg_sample_swap | input | 1 | Move capture to the opposite SCK edge |
| cfg_tick_delay | input | 3 | Extra core cycles before the capture strobe |
| start_valid | input | 1 | Frame request |
| start_ready | output | 1 | Timer idle, frame request accepted |
| bit_valid | input | 1 | Shift engine has another bit |
| bit_ready | output | 1 | Timer takes a bit this cycle |
| sck | output | 1 | Serial clock |
| cs | output | 1 | Chip select |
| shift_stb | output | 1 | Data launch strobe |
| sample_stb | output | 1 | Data capture strobe |

## Verification
The bench runs frames in all four clock modes and with both CS polarities. The high/low splits it uses are symmetric, asymmetric, just above the period clamp and below it, so the individual half lengths can be told apart from the clamped 2+2 case. It also runs a frame in which no bit is taken, which separates the setup-to-hold path from the bit-to-hold path. Tick delays of 0 to 7 are combined with the edge swap so that each capture-edge choice and each delay is distinguishable. Inter-frame gaps range from one cycle to 256 cycles, which checks when the next request is accepted.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;
  typedef enum logic [2:0] {
    TM_IDLE  = 3'd0,
    TM_SETUP = 3'd1,
    TM_BIT   = 3'd2,
    TM_HOLD  = 3'd3,
    TM_GAP   = 3'd4
  } tm_state_e;
endpackage

// File: rtl/spi_tm_halfsel.sv
module spi_tm_halfsel #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic             cpol,
  output logic [CNT_W-1:0] len_first,
  output logic [CNT_W-1:0] len_second
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic             too_short;
  logic [CNT_W-1:0] hi_eff, lo_eff;

  // (hi+1)+(lo+1) < 4 means hi+lo < 2: force 2+2 cycles
  always_comb begin
    sum       = {1'b0, cfg_hi} + {1'b0, cfg_lo};
    too_short = (sum < SUM_W'(2));
    hi_eff    = too_short ? CNT_W'(1) : cfg_hi;
    lo_eff    = too_short ? CNT_W'(1) : cfg_lo;
    // first half of a bit sits at ~cpol
    len_first  = cpol ? lo_eff : hi_eff;
    len_second = cpol ? hi_eff : lo_eff;
  end
endmodule

// File: rtl/spi_tm_seq.sv
module spi_tm_seq
  import spi_tm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [CNT_W-1:0]  len_first,
  input  logic [CNT_W-1:0]  len_second,
  output logic              frame_active,
  output logic              first_half,
  output logic              ev_lead,
  output logic              ev_trail
);
  tm_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             half;
  logic             cnt_zero;

  assign cnt_zero     = (cnt == '0);
  assign start_ready  = (st == TM_IDLE);
  assign frame_active = (st == TM_SETUP) || (st == TM_BIT) || (st == TM_HOLD);
  assign first_half   = (st == TM_BIT) && !half;
  assign bit_ready    = cnt_zero && ((st == TM_SETUP) || ((st == TM_BIT) && half));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TM_IDLE;
      cnt      <= '0;
      half     <= 1'b0;
      ev_lead  <= 1'b0;
      ev_trail <= 1'b0;
    end else begin
      ev_lead  <= 1'b0;
      ev_trail <= 1'b0;
      case (st)
        TM_IDLE: begin
          if (start_valid) begin
            st  <= TM_SETUP;
            cnt <= cfg_setup;
          end
        end
        TM_SETUP: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (bit_valid) begin
            st      <= TM_BIT;
            half    <= 1'b0;
            cnt     <= len_first;
            ev_lead <= 1'b1;
          end else begin
            st  <= TM_HOLD;
            cnt <= cfg_hold;
          end
        end
        TM_BIT: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (!half) begin
            half     <= 1'b1;
            cnt      <= len_second;
            ev_trail <= 1'b1;
          end else if (bit_valid) begin
            half    <= 1'b0;
            cnt     <= len_first;
            ev_lead <= 1'b1;
          end else begin
            st  <= TM_HOLD;
            cnt <= cfg_hold;
          end
        end
        TM_HOLD: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else begin
            st  <= TM_GAP;
            cnt <= CNT_W'(cfg_idle);
          end
        end
        TM_GAP: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else           st  <= TM_IDLE;
        end
        default: st <= TM_IDLE;
      endcase
    end
  end

  // R7: bits are only requested inside an open frame
  p_bit_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> frame_active);

  // R3: a frame only opens after an accepted request
  p_frame_opens_on_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(start_valid && start_ready));

  // R11: leading and trailing edge events never coincide
  p_single_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_lead, ev_trail}));
endmodule

// File: rtl/spi_tm_sample_dly.sv
module spi_tm_sample_dly #(
  parameter int TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_in,
  input  logic [TICK_W-1:0] tick,
  output logic              ev_out
);
  localparam int DEPTH = 1 << TICK_W;

  logic [DEPTH-2:0] dly;
  logic [DEPTH-1:0] tap;

  // tap[k] = ev_in delayed k cycles
  assign tap    = {dly, ev_in};
  assign ev_out = tap[tick];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= '0;
    else        dly <= tap[DEPTH-2:0];
  end

  // R11: with zero delay no strobe appears without an edge event
  p_no_phantom_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == '0 && !ev_in) |-> !ev_out);
endmodule

// File: rtl/spi_sck_cs_timer.sv
module spi_sck_cs_timer #(
  parameter int CNT_W  = 16,
  parameter int IDLE_W = 8,
  parameter int TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_sck_high,
  input  logic [CNT_W-1:0]  cfg_sck_low,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_cs_hold,
  input  logic [IDLE_W-1:0] cfg_cs_idle,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_cs_active_high,
  input  logic              cfg_sample_swap,
  input  logic [TICK_W-1:0] cfg_tick_delay,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              bit_valid,
  output logic              bit_ready,
  output logic              sck,
  output logic              cs,
  output logic              shift_stb,
  output logic              sample_stb
);
  logic [CNT_W-1:0] len_first, len_second;
  logic frame_active, first_half, ev_lead, ev_trail, capture_ev;

  spi_tm_halfsel #(.CNT_W(CNT_W)) u_halfsel (
    .cfg_hi     (cfg_sck_high),
    .cfg_lo     (cfg_sck_low),
    .cpol       (cfg_cpol),
    .len_first  (len_first),
    .len_second (len_second)
  );

  spi_tm_seq #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid  (start_valid),
    .start_ready  (start_ready),
    .bit_valid    (bit_valid),
    .bit_ready    (bit_ready),
    .cfg_setup    (cfg_cs_setup),
    .cfg_hold     (cfg_cs_hold),
    .cfg_idle     (cfg_cs_idle),
    .len_first    (len_first),
    .len_second   (len_second),
    .frame_active (frame_active),
    .first_half   (first_half),
    .ev_lead      (ev_lead),
    .ev_trail     (ev_trail)
  );

  assign sck        = first_half ? ~cfg_cpol : cfg_cpol;
  assign cs         = frame_active ? cfg_cs_active_high : ~cfg_cs_active_high;
  assign shift_stb  = cfg_cpha ? ev_lead : (bit_valid && bit_ready);
  assign capture_ev = (cfg_cpha ^ cfg_sample_swap) ? ev_trail : ev_lead;

  spi_tm_sample_dly #(.TICK_W(TICK_W)) u_sample_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_in  (capture_ev),
    .tick   (cfg_tick_delay),
    .ev_out (sample_stb)
  );

  // R4: SCK rests at its idle level whenever no frame is open
  p_sck_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> (sck == cfg_cpol));

  // R2: an idle timer keeps CS inactive
  p_cs_inactive_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (cs == ~cfg_cs_active_high));

  // R10: launch strobes only inside a frame
  p_shift_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> frame_active);
endmodule

// File: tb/test_spi_sck_cs_timer.sv
module test_spi_sck_cs_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg_sck_high = 16'd1, cfg_sck_low = 16'd1;
  logic [15:0] cfg_cs_setup = 16'd0, cfg_cs_hold = 16'd0;
  logic [7:0]  cfg_cs_idle = 8'd0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_active_high = 1'b0, cfg_sample_swap = 1'b0;
  logic [2:0]  cfg_tick_delay = 3'd0;
  logic start_valid = 1'b0, bit_valid = 1'b0;
  logic start_ready, bit_ready, sck, cs, shift_stb, sample_stb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int n_shift = 0, n_sample = 0;

  // behavioural reference state
  int m_phase = 0;   // 0 idle,1 setup,2 first half,3 second half,4 hold,5 gap
  int m_left  = 0;
  bit m_first = 0;
  bit hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sck_cs_timer i_spi_sck_cs_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_sck_high(cfg_sck_high), .cfg_sck_low(cfg_sck_low),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_hold(cfg_cs_hold), .cfg_cs_idle(cfg_cs_idle),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_cs_active_high(cfg_cs_active_high),
    .cfg_sample_swap(cfg_sample_swap), .cfg_tick_delay(cfg_tick_delay),
    .start_valid(start_valid), .start_ready(start_ready),
    .bit_valid(bit_valid), .bit_ready(bit_ready),
    .sck(sck), .cs(cs), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int half_len(bit want_first);
    int h = cfg_sck_high;
    int l = cfg_sck_low;
    if (h + l < 2) begin h = 1; l = 1; end
    if (want_first) return cfg_cpol ? l : h;
    return cfg_cpol ? h : l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_first = 0;
    end else begin
      m_first = 0;
      case (m_phase)
        0: if (start_valid) begin m_phase = 1; m_left = cfg_cs_setup; end
        1, 3: begin
          if (m_left > 0) m_left--;
          else if (bit_valid) begin m_phase = 2; m_left = half_len(1); m_first = 1; end
          else begin m_phase = 4; m_left = cfg_cs_hold; end
        end
        2: begin
          if (m_left > 0) m_left--;
          else begin m_phase = 3; m_left = half_len(0); m_first = 1; end
        end
        4: if (m_left > 0) m_left--; else begin m_phase = 5; m_left = cfg_cs_idle; end
        5: if (m_left > 0) m_left--; else m_phase = 0;
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    bit e_active, e_ready, e_shift, e_cap, e_samp;
    cycles++;
    if (rst_n) begin
      e_active = (m_phase >= 1 && m_phase <= 4);
      e_ready  = ((m_phase == 1 || m_phase == 3) && m_left == 0);
      e_shift  = cfg_cpha ? (m_phase == 2 && m_first) : (e_ready && bit_valid);
      e_cap    = (cfg_cpha ^ cfg_sample_swap) ? (m_phase == 3 && m_first)
                                               : (m_phase == 2 && m_first);
      hist.push_front(e_cap);
      while (hist.size() > 8) void'(hist.pop_back());
      e_samp = hist[cfg_tick_delay];
      check_eq("R2 R3 R8 cs", cs, e_active ? cfg_cs_active_high : !cfg_cs_active_high);
      check_eq("R4 R5 R6 sck", sck, (m_phase == 2) ? !cfg_cpol : cfg_cpol);
      check_eq("R9 start_ready", start_ready, m_phase == 0);
      check_eq("R7 bit_ready", bit_ready, e_ready);
      check_eq("R10 shift_stb", shift_stb, e_shift);
      check_eq("R11 sample_stb", sample_stb, e_samp);
      if (shift_stb) n_shift++;
      if (sample_stb) n_sample++;
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic set_cfg(int hi, int lo, int su, int ho, int id,
                         bit cpol, bit cpha, bit csh, bit swp, int tick);
    @(posedge clk); #1;
    cfg_sck_high = 16'(hi); cfg_sck_low = 16'(lo);
    cfg_cs_setup = 16'(su); cfg_cs_hold = 16'(ho); cfg_cs_idle = 8'(id);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_cs_active_high = csh;
    cfg_sample_swap = swp; cfg_tick_delay = 3'(tick);
  endtask

  task automatic run_frame(int nbits);
    int left = nbits;
    n_shift = 0; n_sample = 0;
    @(posedge clk); #1;
    start_valid = 1'b1;
    bit_valid   = (nbits > 0);
    do @(negedge clk); while (!start_ready);
    @(posedge clk); #1;
    start_valid = 1'b0;
    while (left > 0) begin
      @(negedge clk);
      if (bit_ready && bit_valid) left--;
      @(posedge clk); #1;
      bit_valid = (left > 0);
    end
    do @(negedge clk); while (!start_ready);
    repeat (8) @(negedge clk);
    check_eq("R10 launch count", n_shift, nbits);
    check_eq("R11 capture count", n_sample, nbits);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) hist.push_back(1'b0);
    repeat (3) @(negedge clk);
    // R1: reset values
    check_eq("R1 cs", cs, 1);
    check_eq("R1 sck", sck, 0);
    check_eq("R1 start_ready", start_ready, 1);
    check_eq("R1 bit_ready", bit_ready, 0);
    check_eq("R1 strobes", {shift_stb, sample_stb}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    // R3 R5 R11: mode 0, symmetric
    set_cfg(1, 1, 2, 1, 3, 0, 0, 0, 0, 0);
    run_frame(4);
    // R2 R4 R10 R11: mode 3, active-high CS, swapped edge, delay 5
    set_cfg(3, 0, 0, 2, 0, 1, 1, 1, 1, 5);
    run_frame(3);
    // R6: clamp from 0+0
    set_cfg(0, 0, 1, 0, 1, 1, 0, 0, 1, 2);
    run_frame(5);
    // R6: clamp from 0+1, delay 7
    set_cfg(0, 1, 0, 0, 0, 0, 1, 0, 0, 7);
    run_frame(2);
    // R5: just above the clamp, asymmetric halves
    set_cfg(0, 2, 3, 3, 2, 0, 0, 1, 0, 1);
    run_frame(6);
    // R7 R8: frame with no bit taken
    set_cfg(2, 2, 4, 2, 1, 0, 0, 0, 0, 0);
    run_frame(0);
    // R9: long gap, mode 2
    set_cfg(5, 9, 1, 0, 255, 1, 0, 0, 0, 3);
    run_frame(3);
    run_frame(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule